// File: doc/BRIEF.md
# Debug Control Register Access Gate

This block decides what happens when a system-register read or write instruction names the main debug control register. One request comes in per valid pulse. It carries the current privilege level (0 to 3), the five encoding fields of the instruction and the access direction. Alongside it come the trap controls set by the higher privilege levels:

- the fine-grained read and write trap bits;
- the level-2 debug trap pair;
- the level-3 debug-access trap;
- the secure-debug-disable conditions;
- the nested-virtualisation mode.

The gate works through a fixed priority chain, and the chain is different at each privilege level. It picks exactly one outcome: undefined, trap to level 2, trap to level 3, redirect to memory, or direct register access.

The outcome is registered one cycle after the request. It is presented as a one-hot vector, together with the exception syndrome class for traps and the memory offset for redirects. It is held until the next request. Delivering the exception and storing the register itself are handled elsewhere.

Top module: `dbg_sysreg_gate`

## Requirements
- R1: Only the encoding op0=2'b10, op1=3'b000, CRn=4'b0000, CRm=4'b0010, op2=3'b010 matches. Any other encoding gives an all-zero result vector, a zero syndrome and a zero offset.
- R2: A matching access from level 0 yields undefined (result bit 0), whatever the trap controls are.
- R3: At level 1, the first check is level-3 undefined priority. When level 3 is present, its undefined-priority condition holds and its debug-access trap is set, the result is undefined, ahead of every other check.
- R4: At level 1, the second check is the fine-grained trap, which yields trap to level 2 (result bit 1). It applies when level 2 is enabled, fine-grained traps are implemented, they are allowed (level 3 is absent or its fine-grained enable is set), and the direction's own bit is set: the read bit for reads, the write bit for writes.
- R5: At level 1, the third check is the level-2 debug trap pair. When level 2 is enabled and either of its two debug trap bits is 1, the result is trap to level 2.
- R6: At level 1, the fourth check is the level-3 debug-access trap. When level 3 is present and this trap is set, the result is undefined if secure-debug-disable applies, and trap to level 3 (result bit 2) otherwise.
- R7: At level 1, when no earlier check applies and the nested-virtualisation mode matches pattern 1x1 (bits 2 and 0 set), the result is redirect (result bit 3) with offset 0x158.
- R8: At level 1, when nothing above applies, the result is direct access (result bit 4).
- R9: At level 2, only the two level-3 checks apply, in the same order as at level 1; otherwise the result is direct access. At level 3, the result is always direct access.
- R10: The syndrome output is 0x18 for both trap outcomes and 0 for every other outcome. The offset output is 0x158 for redirect and 0 for every other outcome.
- R11: The result, syndrome and offset are registered on the clock edge that samples a valid request, and they hold their values until the next valid request. The response-valid output is a one-cycle pulse that follows each request.
- R12: A synchronous active-high reset clears the response-valid output, the result vector, the syndrome and the offset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_el | input | 2 | Current privilege level |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| el3_present | input | 1 | Level 3 is implemented |
| el3_undef_prio | input | 1 | Level-3 undefined-priority condition |
| el3_sdd_undef | input | 1 | Secure-debug-disable makes a level-3 trap undefined |
| el3_tda | input | 1 | Level-3 debug-access trap |
| el3_fgt_en | input | 1 | Level 3 allows fine-grained traps |
| el2_enabled | input | 1 | Level 2 is enabled for the current state |
| el2_tde | input | 1 | Level-2 debug trap bit A |
| el2_tda | input | 1 | Level-2 debug trap bit B |
| fgt_impl | input | 1 | Fine-grained traps are implemented |
| fgt_rd_trap | input | 1 | Fine-grained trap bit for reads |
| fgt_wr_trap | input | 1 | Fine-grained trap bit for writes |
| nv_mode | input | 3 | Nested-virtualisation mode bits |
| rsp_valid | output | 1 | One-cycle pulse after each request |
| rsp_result | output | 5 | One-hot: 0 undefined, 1 trap level 2, 2 trap level 3, 3 redirect, 4 direct |
| rsp_syndrome | output | 6 | Syndrome class for traps |
| rsp_offset | output | 12 | Memory offset for redirect |

## Verification
The bench goes after the ordering of the level-1 chain:

- **Undefined priority over the fine-grained trap.** All level-1 controls are set at once. A design that checked the fine-grained trap before the undefined-priority condition would report a level-2 trap where undefined is expected.
- **Direction-specific fine-grained bit.** A read is issued with only the write bit set, and a write with only the read bit set. A design that mixed up the two bits would trap an access that should go through.
- **Fine-grained traps gated by level 3.** With level 3 present and its fine-grained enable clear, a design that ignored this gate would trap.
- **Level-2 controls at level 2.** A design that leaked the level-2 checks into the level-2 chain would trap where direct access is expected.
- **Nested-virtualisation pattern.** The mode values 111, 101, 100 and 001 are all tried. A design that decoded the pattern too loosely or too tightly would redirect in the wrong cases.
- **Level-3 trap with secure-debug-disable.** A design that dropped this distinction would report trap to level 3 where undefined is expected.
- **Result holding.** Idle cycles are checked to confirm that the result stays put.

// File: rtl/dbgacc_pkg.sv
package dbgacc_pkg;

    localparam int unsigned RES_W       = 5;
    localparam int unsigned RB_UNDEF    = 0;
    localparam int unsigned RB_TRAP_EL2 = 1;
    localparam int unsigned RB_TRAP_EL3 = 2;
    localparam int unsigned RB_REDIRECT = 3;
    localparam int unsigned RB_DIRECT   = 4;

    typedef enum logic [2:0] {
        DEC_NONE     = 3'd0,
        DEC_UNDEF    = 3'd1,
        DEC_TRAP_EL2 = 3'd2,
        DEC_TRAP_EL3 = 3'd3,
        DEC_REDIRECT = 3'd4,
        DEC_DIRECT   = 3'd5
    } decision_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;

    typedef struct packed {
        logic present;
        logic undef_prio;
        logic sdd_undef;
        logic tda;
    } el3_ctl_t;

    typedef struct packed {
        logic enabled;
        logic tde;
        logic tda;
        logic fgt_rd;
        logic fgt_wr;
    } el2_ctl_t;

    typedef struct packed {
        logic undef_hi;   // undefined ahead of all other checks
        logic tda_hit;    // debug-access trap active
        logic tda_undef;  // that trap turns into undefined
    } el3_verdict_t;

    function automatic logic [RES_W-1:0] dec_onehot(input decision_e d);
        logic [RES_W-1:0] v;
        v = '0;
        case (d)
            DEC_UNDEF:    v[RB_UNDEF]    = 1'b1;
            DEC_TRAP_EL2: v[RB_TRAP_EL2] = 1'b1;
            DEC_TRAP_EL3: v[RB_TRAP_EL3] = 1'b1;
            DEC_REDIRECT: v[RB_REDIRECT] = 1'b1;
            DEC_DIRECT:   v[RB_DIRECT]   = 1'b1;
            default:      v = '0;
        endcase
        return v;
    endfunction

    function automatic logic dec_is_trap(input decision_e d);
        return (d == DEC_TRAP_EL2) || (d == DEC_TRAP_EL3);
    endfunction

endpackage

// File: rtl/dbgacc_enc_match.sv
module dbgacc_enc_match
    import dbgacc_pkg::*;
#(
    parameter logic [1:0] ENC_OP0 = 2'b10,
    parameter logic [2:0] ENC_OP1 = 3'b000,
    parameter logic [3:0] ENC_CRN = 4'b0000,
    parameter logic [3:0] ENC_CRM = 4'b0010,
    parameter logic [2:0] ENC_OP2 = 3'b010
) (
    input  sysenc_t enc,
    output logic    hit
);
    localparam sysenc_t TARGET = '{op0: ENC_OP0, op1: ENC_OP1, crn: ENC_CRN,
                                   crm: ENC_CRM, op2: ENC_OP2};
    localparam int unsigned ENC_W = $bits(sysenc_t);

    logic [ENC_W-1:0] bit_eq;

    for (genvar i = 0; i < ENC_W; i++) begin : g_cmp
        assign bit_eq[i] = (enc[i] == TARGET[i]);
    end

    assign hit = &bit_eq;

endmodule

// File: rtl/dbgacc_el3_gate.sv
module dbgacc_el3_gate
    import dbgacc_pkg::*;
(
    input  el3_ctl_t     ctl,
    output el3_verdict_t verdict
);
    always_comb begin
        verdict.undef_hi  = ctl.present & ctl.undef_prio & ctl.tda;
        verdict.tda_hit   = ctl.present & ctl.tda;
        verdict.tda_undef = ctl.sdd_undef;
    end
endmodule

// File: rtl/dbgacc_decide.sv
module dbgacc_decide
    import dbgacc_pkg::*;
#(
    parameter int unsigned     NV_W     = 3,
    parameter logic [NV_W-1:0] NV_MASK  = 3'b101,
    parameter logic [NV_W-1:0] NV_MATCH = 3'b101
) (
    input  logic            hit,
    input  logic [1:0]      el,
    input  logic            write,
    input  logic            el3_present,
    input  logic            el3_fgt_en,
    input  logic            fgt_impl,
    input  el2_ctl_t        el2,
    input  el3_verdict_t    v3,
    input  logic [NV_W-1:0] nv_mode,
    output decision_e       dec
);
    logic fgt_bit;
    logic fgt_allowed;
    logic fgt_trap;
    logic el2_pair_trap;
    logic nv_redirect;
    decision_e el3_tail;

    assign fgt_bit       = write ? el2.fgt_wr : el2.fgt_rd;
    assign fgt_allowed   = fgt_impl & (~el3_present | el3_fgt_en);
    assign fgt_trap      = el2.enabled & fgt_allowed & fgt_bit;
    assign el2_pair_trap = el2.enabled & (el2.tde | el2.tda);
    assign nv_redirect   = ((nv_mode & NV_MASK) == NV_MATCH);

    always_comb begin
        el3_tail = v3.tda_undef ? DEC_UNDEF : DEC_TRAP_EL3;
    end

    always_comb begin
        dec = DEC_NONE;
        if (hit) begin
            case (el)
                2'd0: dec = DEC_UNDEF;
                2'd1: begin
                    if (v3.undef_hi)        dec = DEC_UNDEF;
                    else if (fgt_trap)      dec = DEC_TRAP_EL2;
                    else if (el2_pair_trap) dec = DEC_TRAP_EL2;
                    else if (v3.tda_hit)    dec = el3_tail;
                    else if (nv_redirect)   dec = DEC_REDIRECT;
                    else                    dec = DEC_DIRECT;
                end
                2'd2: begin
                    if (v3.undef_hi)        dec = DEC_UNDEF;
                    else if (v3.tda_hit)    dec = el3_tail;
                    else                    dec = DEC_DIRECT;
                end
                default: dec = DEC_DIRECT;
            endcase
        end
    end
endmodule

// File: rtl/dbgacc_rsp_reg.sv
module dbgacc_rsp_reg
    import dbgacc_pkg::*;
#(
    parameter int unsigned      EC_W      = 6,
    parameter int unsigned      OFS_W     = 12,
    parameter logic [EC_W-1:0]  TRAP_EC   = 6'h18,
    parameter logic [OFS_W-1:0] REDIR_OFS = 12'h158
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  decision_e        dec,
    output logic             rsp_valid,
    output logic [RES_W-1:0] rsp_result,
    output logic [EC_W-1:0]  rsp_syndrome,
    output logic [OFS_W-1:0] rsp_offset
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_result   <= '0;
            rsp_syndrome <= '0;
            rsp_offset   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_result   <= dec_onehot(dec);
                rsp_syndrome <= dec_is_trap(dec) ? TRAP_EC : '0;
                rsp_offset   <= (dec == DEC_REDIRECT) ? REDIR_OFS : '0;
            end
        end
    end
endmodule

// File: rtl/dbg_sysreg_gate.sv
module dbg_sysreg_gate
    import dbgacc_pkg::*;
#(
    parameter int unsigned      EC_W      = 6,
    parameter int unsigned      OFS_W     = 12,
    parameter int unsigned      NV_W      = 3,
    parameter logic [EC_W-1:0]  TRAP_EC   = 6'h18,
    parameter logic [OFS_W-1:0] REDIR_OFS = 12'h158,
    parameter logic [NV_W-1:0]  NV_MASK   = 3'b101,
    parameter logic [NV_W-1:0]  NV_MATCH  = 3'b101,
    parameter logic [1:0]       ENC_OP0   = 2'b10,
    parameter logic [2:0]       ENC_OP1   = 3'b000,
    parameter logic [3:0]       ENC_CRN   = 4'b0000,
    parameter logic [3:0]       ENC_CRM   = 4'b0010,
    parameter logic [2:0]       ENC_OP2   = 3'b010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_el,
    input  logic             req_write,
    input  logic [1:0]       req_op0,
    input  logic [2:0]       req_op1,
    input  logic [3:0]       req_crn,
    input  logic [3:0]       req_crm,
    input  logic [2:0]       req_op2,
    input  logic             el3_present,
    input  logic             el3_undef_prio,
    input  logic             el3_sdd_undef,
    input  logic             el3_tda,
    input  logic             el3_fgt_en,
    input  logic             el2_enabled,
    input  logic             el2_tde,
    input  logic             el2_tda,
    input  logic             fgt_impl,
    input  logic             fgt_rd_trap,
    input  logic             fgt_wr_trap,
    input  logic [NV_W-1:0]  nv_mode,
    output logic             rsp_valid,
    output logic [4:0]       rsp_result,
    output logic [EC_W-1:0]  rsp_syndrome,
    output logic [OFS_W-1:0] rsp_offset
);
    sysenc_t      enc;
    el3_ctl_t     c3;
    el2_ctl_t     c2;
    el3_verdict_t v3;
    logic         enc_hit;
    decision_e    dec;

    assign enc = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};
    assign c3  = '{present: el3_present, undef_prio: el3_undef_prio,
                   sdd_undef: el3_sdd_undef, tda: el3_tda};
    assign c2  = '{enabled: el2_enabled, tde: el2_tde, tda: el2_tda,
                   fgt_rd: fgt_rd_trap, fgt_wr: fgt_wr_trap};

    dbgacc_enc_match #(
        .ENC_OP0(ENC_OP0), .ENC_OP1(ENC_OP1), .ENC_CRN(ENC_CRN),
        .ENC_CRM(ENC_CRM), .ENC_OP2(ENC_OP2)
    ) u_match (
        .enc (enc),
        .hit (enc_hit)
    );

    dbgacc_el3_gate u_el3 (
        .ctl     (c3),
        .verdict (v3)
    );

    dbgacc_decide #(
        .NV_W(NV_W), .NV_MASK(NV_MASK), .NV_MATCH(NV_MATCH)
    ) u_decide (
        .hit         (enc_hit),
        .el          (req_el),
        .write       (req_write),
        .el3_present (el3_present),
        .el3_fgt_en  (el3_fgt_en),
        .fgt_impl    (fgt_impl),
        .el2         (c2),
        .v3          (v3),
        .nv_mode     (nv_mode),
        .dec         (dec)
    );

    dbgacc_rsp_reg #(
        .EC_W(EC_W), .OFS_W(OFS_W), .TRAP_EC(TRAP_EC), .REDIR_OFS(REDIR_OFS)
    ) u_rsp (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .dec          (dec),
        .rsp_valid    (rsp_valid),
        .rsp_result   (rsp_result),
        .rsp_syndrome (rsp_syndrome),
        .rsp_offset   (rsp_offset)
    );

    // ---------------- assertions ----------------
    p_result_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_result));

    p_nomatch_zero_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid && !enc_hit |=> (rsp_result == '0) && (rsp_syndrome == '0) && (rsp_offset == '0));

    p_el0_undef_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && enc_hit && (req_el == 2'd0) |=> rsp_result[RB_UNDEF]);

    p_undef_first_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid && enc_hit && (req_el == 2'd1) && el3_present && el3_undef_prio && el3_tda
        |=> rsp_result[RB_UNDEF]);

    p_el3_direct_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid && enc_hit && (req_el == 2'd3) |=> rsp_result[RB_DIRECT]);

    p_el2_no_el2trap_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid && (req_el == 2'd2) |=> !rsp_result[RB_TRAP_EL2] && !rsp_result[RB_REDIRECT]);

    p_syndrome_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_syndrome != '0) == (rsp_result[RB_TRAP_EL2] || rsp_result[RB_TRAP_EL3]));

    p_offset_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_offset != '0) == rsp_result[RB_REDIRECT]);

    p_valid_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && $stable(rsp_result) && $stable(rsp_syndrome) && $stable(rsp_offset));

endmodule

// File: tb/tb_dbg_sysreg_gate.sv
`timescale 1ns/1ps
module tb_dbg_sysreg_gate;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, req_valid, req_write;
    logic [1:0] req_el, req_op0;
    logic [2:0] req_op1, req_op2, nv_mode;
    logic [3:0] req_crn, req_crm;
    logic e3p, e3u, e3s, e3t, e3f, e2e, e2d, e2a, fi, fr, fw;
    logic rsp_valid;
    logic [4:0] rsp_result;
    logic [5:0] rsp_syndrome;
    logic [11:0] rsp_offset;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    dbg_sysreg_gate dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_el(req_el), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
        .el3_present(e3p), .el3_undef_prio(e3u), .el3_sdd_undef(e3s), .el3_tda(e3t),
        .el3_fgt_en(e3f), .el2_enabled(e2e), .el2_tde(e2d), .el2_tda(e2a),
        .fgt_impl(fi), .fgt_rd_trap(fr), .fgt_wr_trap(fw), .nv_mode(nv_mode),
        .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_syndrome(rsp_syndrome),
        .rsp_offset(rsp_offset)
    );

    // Reference model: result one-hot {direct,redirect,trap3,trap2,undef} and rule tag
    function automatic logic [4:0] model(output string tag);
        logic m;
        m = (req_op0 == 2'b10) && (req_op1 == 3'b000) && (req_crn == 4'b0000)
            && (req_crm == 4'b0010) && (req_op2 == 3'b010);
        if (!m) begin tag = "R1"; return 5'b00000; end
        case (req_el)
            2'd0: begin tag = "R2"; return 5'b00001; end
            2'd1: begin
                if (e3p && e3u && e3t) begin tag = "R3"; return 5'b00001; end
                if (e2e && fi && (!e3p || e3f) && (req_write ? fw : fr)) begin tag = "R4"; return 5'b00010; end
                if (e2e && (e2d || e2a)) begin tag = "R5"; return 5'b00010; end
                if (e3p && e3t) begin tag = "R6"; return e3s ? 5'b00001 : 5'b00100; end
                if (nv_mode[2] && nv_mode[0]) begin tag = "R7"; return 5'b01000; end
                tag = "R8"; return 5'b10000;
            end
            2'd2: begin
                tag = "R9";
                if (e3p && e3u && e3t) return 5'b00001;
                if (e3p && e3t) return e3s ? 5'b00001 : 5'b00100;
                return 5'b10000;
            end
            default: begin tag = "R9"; return 5'b10000; end
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_match();
        req_op0 = 2'b10; req_op1 = 3'b000; req_crn = 4'b0000; req_crm = 4'b0010; req_op2 = 3'b010;
    endtask

    task automatic clear_ctl();
        {e3p, e3u, e3s, e3t, e3f, e2e, e2d, e2a, fi, fr, fw} = '0;
        nv_mode = 3'b000;
    endtask

    // Issue one request with the current fields, then check at the following negedge
    task automatic issue();
        string tag;
        logic [4:0] er;
        er = model(tag);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", 32'(rsp_valid), 32'd1, "valid pulse");
        chk(tag, 32'(rsp_result), 32'(er), "result");
        chk("R10", 32'(rsp_syndrome), (er[1] || er[2]) ? 32'h18 : 32'h0, "syndrome");
        chk("R10", 32'(rsp_offset), er[3] ? 32'h158 : 32'h0, "offset");
    endtask

    task automatic idle_hold();
        logic [4:0] r; logic [5:0] s; logic [11:0] o;
        r = rsp_result; s = rsp_syndrome; o = rsp_offset;
        @(posedge clk); @(negedge clk);
        chk("R11", 32'(rsp_valid), 32'd0, "valid after idle");
        chk("R11", {15'd0, rsp_result, rsp_offset}, {15'd0, r, o}, "held result/offset");
        chk("R11", 32'(rsp_syndrome), 32'(s), "held syndrome");
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
                $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_el = 2'd1;
        set_match(); clear_ctl();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", {26'd0, rsp_valid, rsp_result}, 32'd0, "reset valid/result");
        chk("R12", {14'd0, rsp_syndrome, rsp_offset}, 32'd0, "reset syndrome/offset");
        rst = 1'b0;

        // R8 plain direct
        req_el = 2'd1; issue();
        idle_hold(); idle_hold();
        // R1 mismatch on each field
        req_op0 = 2'b11; issue(); set_match();
        req_op1 = 3'b001; issue(); set_match();
        req_crn = 4'b0001; issue(); set_match();
        req_crm = 4'b0011; issue(); set_match();
        req_op2 = 3'b011; issue(); set_match();
        // R2 level 0 with nothing and everything set
        req_el = 2'd0; issue();
        {e3p, e3u, e3s, e3t, e3f, e2e, e2d, e2a, fi, fr, fw} = '1; nv_mode = 3'b111; issue();
        // R3 everything set at level 1
        req_el = 2'd1; issue();
        // R4 read with only the write bit, and write with only the read bit
        clear_ctl(); e2e = 1; fi = 1; fw = 1; req_write = 0; issue();
        req_write = 1; issue();
        fw = 0; fr = 1; issue();
        req_write = 0; issue();
        // R4 blocked by level 3 present without fine-grained enable
        e3p = 1; e3f = 0; issue();
        e3f = 1; issue();
        // R5 pair bits
        clear_ctl(); e2e = 1; e2d = 1; issue();
        e2d = 0; e2a = 1; issue();
        e2e = 0; issue();
        // R6 level-3 trap with and without secure-debug-disable
        clear_ctl(); e3p = 1; e3t = 1; issue(); idle_hold();
        e3s = 1; issue();
        e3p = 0; issue();
        // R7 pattern values
        clear_ctl(); nv_mode = 3'b101; issue(); idle_hold();
        nv_mode = 3'b111; issue();
        nv_mode = 3'b100; issue();
        nv_mode = 3'b001; issue();
        // R9 level 2 ignores level-2 controls and redirect
        clear_ctl(); req_el = 2'd2; e2e = 1; e2d = 1; e2a = 1; fi = 1; fr = 1; fw = 1; nv_mode = 3'b101; issue();
        e3p = 1; e3t = 1; issue();
        e3u = 1; issue();
        req_el = 2'd3; issue();

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            req_el = 2'($urandom); req_write = 1'($urandom);
            {e3p, e3u, e3s, e3t, e3f, e2e, e2d, e2a, fi, fr, fw} = 11'($urandom);
            nv_mode = 3'($urandom);
            set_match();
            if (($urandom % 8) == 0) begin
                req_op0 = 2'($urandom); req_op1 = 3'($urandom); req_crn = 4'($urandom);
                req_crm = 4'($urandom); req_op2 = 3'($urandom);
            end
            issue();
            if (($urandom % 5) == 0) idle_hold();
        end

        // R12 reset mid-run clears held state
        @(negedge clk); rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        chk("R12", {26'd0, rsp_valid, rsp_result}, 32'd0, "reset after traffic");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule